// File: doc/BRIEF.md
# CAN Controller Power-Mode Sequencer

This block holds the mode-control logic of a CAN protocol controller. It decides when the controller enters and leaves a debug freeze and a low-power stop. It also decides when the controller is allowed to take part in bus traffic again. The frame engine, bit timing and message buffers sit outside the block. They feed it a synchronous bit strobe, a bus-idle indication, a marker for the third intermission bit position, a bus-off indication and a busy flag for internal activity.

Software drives the control inputs: halt, stop set and stop clear, self-wake enable, wake mask, wake-flag clear and soft reset. An external freeze line can also request debug freeze. In return, the block gives acknowledge flags, a not-ready flag, a clock enable for the gated part of the controller, a transmit override that forces recessive, a no-arbitration flag, a bus-participation flag, and a sticky wake flag with a masked interrupt.

The block runs on a clock that is never gated. The receive line is brought in through a two-flop synchronizer. A bit value of 1 is recessive and 0 is dominant.

Top module: `can_pwr_seq`

## Requirements
- R1: While reset is asserted, the outputs take these values: `frz_ack`, `stop_ack`, `stop_req`, `bus_on`, `no_arb`, `wake_flag` and `wake_irq` are 0, and `clk_en`, `not_ready` and `tx_force_rec` are 1.
- R2: Freeze timing:
  - `frz_ack` rises one clock after `frz_line` or `ctl_halt` goes high, provided no stop is pending.
  - It falls one clock after both are low.
  - While `frz_ack` is high, `not_ready` is 1.
- R3: After reset or after leaving freeze, `bus_on` goes to 1 at the `bit_tick` that samples the 11th consecutive recessive (1) bit. A dominant (0) bit restarts the count. `not_ready` and `tx_force_rec` stay 1 until then.
- R4: After a stop request, stop is not entered until one of two things happens: `bus_idle` is high, or a `bit_tick` samples a recessive bit while `ifs_third` is high.
- R5: Once that bus condition is met, `stop_ack` rises one clock after `core_busy` is low, and never while `core_busy` holds it off.
- R6: While `stop_ack` is 1, the outputs are held as follows, and bit ticks do not advance the recessive count:
  - `clk_en` is 0.
  - `tx_force_rec` is 1.
  - `not_ready` is 1.
  - `bus_on` is 0.
- R7: Wake flag behaviour:
  - While stopped, a synchronized recessive-to-dominant edge on `rx` sets `wake_flag` three clocks after the change on `rx`.
  - The flag stays set until a `ctl_wake_clr` pulse.
  - Edges outside stop never set it.
- R8: `wake_irq` is 1 exactly when `wake_flag` is 1 and `ctl_wake_mask` is 1.
- R9: Self-wake:
  - The value of `ctl_selfwake` is latched on stop entry.
  - If it was 1, the waking edge clears `stop_req`, drops `stop_ack` and restores `clk_en`.
  - Outside bus-off, the same edge also sets `bus_on` and `no_arb`.
  - `no_arb` clears one clock after `bus_idle`.
- R10: If self-wake was 0 at stop entry, a wake edge sets only the flag and the block stays stopped.
- R11: Recessive count across stop:
  - If stop is entered while `bus_off` is 1, the recessive count keeps its value and resumes from it after stop is left.
  - Outside bus-off, stop entry resets the count.
- R12: Ways out of a pending or active stop:
  - A `ctl_stop_clr` pulse cancels it, and the block is running two clocks later.
  - A `ctl_soft_rst` pulse does the same one clock later and also restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous module reset, active low |
| rx | input | 1 | Raw receive line, 1 = recessive |
| bit_tick | input | 1 | One-clock strobe at each bit sample point |
| bus_idle | input | 1 | Bus is idle |
| ifs_third | input | 1 | Current bit is the third intermission bit |
| bus_off | input | 1 | Controller is in bus-off |
| core_busy | input | 1 | Internal activity outside the bus interface is still running |
| frz_line | input | 1 | External freeze request |
| ctl_halt | input | 1 | Software halt bit |
| ctl_stop_set | input | 1 | Pulse: software sets the stop bit |
| ctl_stop_clr | input | 1 | Pulse: software clears the stop bit |
| ctl_selfwake | input | 1 | Self-wake enable |
| ctl_wake_mask | input | 1 | Wake interrupt enable |
| ctl_wake_clr | input | 1 | Pulse: clear the wake flag |
| ctl_soft_rst | input | 1 | Pulse: synchronous soft reset |
| stop_req | output | 1 | Current stop bit |
| frz_ack | output | 1 | Freeze is in effect |
| stop_ack | output | 1 | Low-power stop is in effect |
| not_ready | output | 1 | Not participating on the bus |
| clk_en | output | 1 | Enable for the gated internal clock |
| tx_force_rec | output | 1 | Force the transmit pin recessive |
| no_arb | output | 1 | Receive the current frame without arbitrating |
| bus_on | output | 1 | Synchronized to the bus |
| wake_flag | output | 1 | Sticky wake status |
| wake_irq | output | 1 | Masked wake interrupt |

## Verification
The checker watches several rules on every cycle:
- every rise of `frz_ack` must have a freeze request behind it;
- every rise of `stop_ack` must come after internal activity has ended;
- the wake flag may rise only from the stopped state;
- while stopped, the block must be off the bus with its clock gated;
- `bus_on` may rise only on a bit strobe or on a self-wake;
- the interrupt stays silent while it is masked.

The exact count of 11 recessive bits, the way a dominant bit restarts that count, the count being held across stop during bus-off, and the full mask/self-wake combinations are shown only by the bench's sweeps.

// File: rtl/can_pwr_seq.sv
module can_pwr_seq #(
  parameter int REJOIN_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  input  logic bit_tick,
  input  logic bus_idle,
  input  logic ifs_third,
  input  logic bus_off,
  input  logic core_busy,
  input  logic frz_line,
  input  logic ctl_halt,
  input  logic ctl_stop_set,
  input  logic ctl_stop_clr,
  input  logic ctl_selfwake,
  input  logic ctl_wake_mask,
  input  logic ctl_wake_clr,
  input  logic ctl_soft_rst,
  output logic stop_req,
  output logic frz_ack,
  output logic stop_ack,
  output logic not_ready,
  output logic clk_en,
  output logic tx_force_rec,
  output logic no_arb,
  output logic bus_on,
  output logic wake_flag,
  output logic wake_irq
);
  localparam int CW = $clog2(REJOIN_BITS);
  localparam logic [CW-1:0] LAST = CW'(REJOIN_BITS - 1);

  typedef enum logic [2:0] {M_RUN, M_FRZ, M_WBUS, M_WCORE, M_STOP} mode_t;

  mode_t mode;
  logic rx_m, rx_s, rx_d;
  logic sw_lat, synced;
  logic [CW-1:0] cnt;

  wire frz_req    = frz_line | ctl_halt;
  wire stopped    = (mode == M_STOP);
  wire wake_edge  = stopped & rx_d & ~rx_s;
  wire self_wake  = wake_edge & sw_lat;
  wire bus_gap    = bus_idle | (ifs_third & bit_tick & rx_s);
  wire enter_stop = (mode == M_WCORE) & stop_req & ~core_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_m, rx_s, rx_d} <= 3'b111;
    else begin
      rx_m <= rx;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stop_req <= 1'b0;
    else if (ctl_soft_rst || self_wake || ctl_stop_clr) stop_req <= 1'b0;
    else if (ctl_stop_set) stop_req <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= M_RUN;
    else if (ctl_soft_rst) mode <= M_RUN;
    else case (mode)
      M_RUN:   if (stop_req) mode <= M_WBUS;
               else if (frz_req) mode <= M_FRZ;
      M_FRZ:   if (!frz_req) mode <= M_RUN;
      M_WBUS:  if (!stop_req) mode <= M_RUN;
               else if (bus_gap) mode <= M_WCORE;
      M_WCORE: if (!stop_req) mode <= M_RUN;
               else if (!core_busy) mode <= M_STOP;
      M_STOP:  if (!stop_req || self_wake) mode <= M_RUN;
      default: mode <= M_RUN;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sw_lat <= 1'b0;
    else if (ctl_soft_rst) sw_lat <= 1'b0;
    else if (enter_stop) sw_lat <= ctl_selfwake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      synced <= 1'b0;
      cnt    <= '0;
    end else if (ctl_soft_rst || mode == M_FRZ) begin
      synced <= 1'b0;
      cnt    <= '0;
    end else if (enter_stop) begin
      synced <= 1'b0;
      if (!bus_off) cnt <= '0;
    end else if (self_wake) begin
      if (!bus_off) begin
        synced <= 1'b1;
        cnt    <= '0;
      end
    end else if (!stopped && !synced && bit_tick) begin
      if (!rx_s) cnt <= '0;
      else if (cnt == LAST) begin
        cnt    <= '0;
        synced <= 1'b1;
      end else cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) no_arb <= 1'b0;
    else if (ctl_soft_rst) no_arb <= 1'b0;
    else if (self_wake && !bus_off) no_arb <= 1'b1;
    else if (bus_idle) no_arb <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wake_flag <= 1'b0;
    else if (ctl_soft_rst) wake_flag <= 1'b0;
    else if (wake_edge) wake_flag <= 1'b1;
    else if (ctl_wake_clr) wake_flag <= 1'b0;

  assign frz_ack      = (mode == M_FRZ);
  assign stop_ack     = stopped;
  assign clk_en       = ~stopped;
  assign bus_on       = synced;
  assign not_ready    = frz_ack | stopped | ~synced;
  assign tx_force_rec = not_ready;
  assign wake_irq     = wake_flag & ctl_wake_mask;
endmodule

// File: rtl/can_pwr_seq_chk.sv
module can_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic core_busy,
  input logic frz_line,
  input logic ctl_halt,
  input logic ctl_wake_mask,
  input logic frz_ack,
  input logic stop_ack,
  input logic clk_en,
  input logic tx_force_rec,
  input logic bus_on,
  input logic wake_flag,
  input logic wake_irq
);
  AST_FRZ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(frz_line | ctl_halt)); // R2
  AST_JOIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_on) |-> ($past(bit_tick) || $past(stop_ack))); // R3
  AST_STOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(!core_busy)); // R5
  AST_STOPPED_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> (!bus_on && tx_force_rec && !clk_en)); // R6
  AST_WAKE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(stop_ack)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wake_mask |-> !wake_irq); // R8
endmodule

bind can_pwr_seq can_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .core_busy(core_busy),
  .frz_line(frz_line), .ctl_halt(ctl_halt), .ctl_wake_mask(ctl_wake_mask),
  .frz_ack(frz_ack), .stop_ack(stop_ack), .clk_en(clk_en),
  .tx_force_rec(tx_force_rec), .bus_on(bus_on), .wake_flag(wake_flag),
  .wake_irq(wake_irq)
);

// File: tb/sim_can_pwr_seq.sv
`timescale 1ns/1ps
module sim_can_pwr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, bit_tick = 0, bus_idle = 0, ifs_third = 0, bus_off = 0, core_busy = 0;
  logic frz_line = 0, ctl_halt = 0, ctl_stop_set = 0, ctl_stop_clr = 0, ctl_selfwake = 0;
  logic ctl_wake_mask = 0, ctl_wake_clr = 0, ctl_soft_rst = 0;
  logic stop_req, frz_ack, stop_ack, not_ready, clk_en, tx_force_rec, no_arb, bus_on, wake_flag, wake_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_pwr_seq u0 (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    cyc(3);
    bit_tick = 1;
    cyc(1);
    bit_tick = 0;
  endtask

  task automatic send_rec(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic pulse_stop_set();
    ctl_stop_set = 1; cyc(1); ctl_stop_set = 0;
  endtask

  task automatic go_stop();
    bus_idle = 1; core_busy = 0;
    pulse_stop_set();
    cyc(3);
    bus_idle = 0;
  endtask

  task automatic leave_stop_sw();
    ctl_stop_clr = 1; cyc(1); ctl_stop_clr = 0; cyc(1);
  endtask

  task automatic bounce_freeze();
    ctl_halt = 1; cyc(1); ctl_halt = 0; cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 frz_ack", frz_ack, 0);   chk("R1 stop_ack", stop_ack, 0);
    chk("R1 clk_en", clk_en, 1);     chk("R1 not_ready", not_ready, 1);
    chk("R1 tx_force_rec", tx_force_rec, 1); chk("R1 bus_on", bus_on, 0);
    chk("R1 wake_flag", wake_flag, 0); chk("R1 no_arb", no_arb, 0);
    chk("R1 stop_req", stop_req, 0);
    rst_n = 1; cyc(1);

    for (int k = 0; k <= 10; k++) begin
      if (k % 2 == 0) frz_line = 1; else ctl_halt = 1;
      cyc(1);
      chk("R2 frz_ack rise", frz_ack, 1);
      chk("R2 not_ready in freeze", not_ready, 1);
      frz_line = 0; ctl_halt = 0;
      cyc(1);
      chk("R2 frz_ack fall", frz_ack, 0);
      send_rec(k);
      chk("R3 not joined before dominant", bus_on, 0);
      send_bit(1'b0);
      send_rec(10);
      chk("R3 ten recessive not enough", bus_on, 0);
      chk("R3 tx forced before join", tx_force_rec, 1);
      send_rec(1);
      chk("R3 joined at eleventh", bus_on, 1);
      chk("R3 ready after join", not_ready, 0);
    end
    rx = 0; cyc(4); rx = 1; cyc(4);
    chk("R7 no wake outside stop", wake_flag, 0);

    core_busy = 1; ifs_third = 1;
    pulse_stop_set();
    cyc(6);
    chk("R4 waits for bus gap", stop_ack, 0);
    send_bit(1'b0);
    cyc(2);
    chk("R4 dominant third bit no entry", stop_ack, 0);
    send_bit(1'b1);
    ifs_third = 0;
    cyc(3);
    chk("R5 waits for core", stop_ack, 0);
    core_busy = 0; cyc(1);
    chk("R5 stop entered", stop_ack, 1);
    chk("R6 clk gated", clk_en, 0);
    chk("R6 tx recessive", tx_force_rec, 1);
    chk("R6 not_ready", not_ready, 1);
    chk("R6 off bus", bus_on, 0);
    leave_stop_sw();
    chk("R12 sw clear exits stop", stop_ack, 0);

    for (int c = 0; c < 4; c++) begin
      logic m, s;
      m = c[0]; s = c[1];
      ctl_wake_mask = m; ctl_selfwake = s; rx = 1;
      cyc(3);
      go_stop();
      chk("R6 stopped before wake", stop_ack, 1);
      ctl_selfwake = ~s;
      rx = 0; cyc(3);
      chk("R7 flag set by edge", wake_flag, 1);
      chk("R8 irq follows mask", wake_irq, m);
      chk("R9 R10 stop_ack after edge", stop_ack, ~s);
      chk("R9 R10 clk_en after edge", clk_en, s);
      chk("R9 no_arb after edge", no_arb, s);
      chk("R9 bus_on after self wake", bus_on, s);
      chk("R9 stop_req cleared", stop_req, ~s);
      rx = 1; cyc(5);
      chk("R7 flag sticky", wake_flag, 1);
      ctl_wake_clr = 1; cyc(1); ctl_wake_clr = 0;
      chk("R7 flag cleared", wake_flag, 0);
      chk("R8 irq cleared", wake_irq, 0);
      if (s) begin
        bus_idle = 1; cyc(1); bus_idle = 0;
        chk("R9 no_arb ends on idle", no_arb, 0);
      end else begin
        leave_stop_sw();
        chk("R12 sw clear after wake", stop_ack, 0);
      end
    end
    ctl_selfwake = 0; ctl_wake_mask = 0;

    for (int p = 1; p <= 10; p++) begin
      bounce_freeze();
      send_rec(p);
      bus_off = 1;
      go_stop();
      send_rec(3);
      chk("R6 ticks ignored in stop", bus_on, 0);
      leave_stop_sw();
      if (p < 10) begin
        send_rec(10 - p);
        chk("R11 count held, one short", bus_on, 0);
      end
      send_rec(1);
      chk("R11 count resumed", bus_on, 1);
      bus_off = 0;
    end

    bounce_freeze();
    send_rec(5);
    go_stop();
    leave_stop_sw();
    send_rec(10);
    chk("R11 count reset outside bus-off", bus_on, 0);
    send_rec(1);
    chk("R11 rejoin after full count", bus_on, 1);

    go_stop();
    ctl_soft_rst = 1; cyc(1); ctl_soft_rst = 0;
    chk("R12 soft reset stop_ack", stop_ack, 0);
    chk("R12 soft reset stop_req", stop_req, 0);
    chk("R12 soft reset clk_en", clk_en, 1);
    chk("R12 soft reset bus_on", bus_on, 0);

    pulse_stop_set();
    cyc(3);
    ctl_stop_clr = 1; cyc(1); ctl_stop_clr = 0;
    bus_idle = 1; cyc(4); bus_idle = 0;
    chk("R12 abandoned stop", stop_ack, 0);
    chk("R12 abandoned stop clk", clk_en, 1);

    finish_run();
  end
endmodule